// File: doc/BRIEF.md
# Source-Synchronous Receive Sample Deframer

This block sits behind the deserializers of a source-synchronous serial receive link. On every user-clock cycle it is handed a short slice of already-deserialized bits from each of four data lanes and from a strobe lane. It gathers these slices until one complex sample is complete: a 16-bit in-phase word and a 16-bit quadrature word. It then presents the sample with a single-cycle valid pulse.

Mode inputs set the lane count (one, two or four), single or double data-rate capture, and whether the link carries narrow symbols instead of full I/Q words. Symbols can be 16 or 8 bits wide. The number of user clocks per sample follows from these inputs. The strobe lane marks where each sample begins. After the first mark the block keeps counting samples on its own, and every later mark realigns the count.

The mode inputs are only changed while reset is held.

Top module: `ssiRxDeframer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `validOut` is low and `iData`/`qData` are zero.
- R2: Without symbol mode, bits arrive MSB first on each lane.
  - In one-lane mode, lane 0 carries I then Q.
  - In two-lane mode, lane 0 (`laneData[7:0]`) carries I and lane 1 (`laneData[15:8]`) carries Q.
  - In four-lane mode, lanes 0 to 3 carry I high byte, I low byte, Q high byte and Q low byte.
  - Unused lanes have no effect on the output.
- R3: With `sdrSel`=1, each cycle takes 4 bits per lane from slice bits [7:4], and bit 7 is first in time. With `sdrSel`=0, each cycle takes all 8 slice bits, and bit 7 is first in time.
- R4: With `symbEn`=1, only lane 0 is used and `laneCount` is ignored.
  - A symbol is 16 bits, or 8 bits when `symbNarrow`=1.
  - The first half of the symbol goes to the top of `iData` and the second half to the top of `qData`.
  - All lower bits are zero.
- R5: The number of user clocks per sample is the bits per lane per sample divided by the bits per lane per clock.
  - Bits per lane per sample: 32, 16 or 8 for one, two or four lanes, or the symbol width in symbol mode.
  - Bits per lane per clock: 4 in SDR, 8 in DDR.
  - This gives ratios from 8 down to 1.
- R6: `validOut` is high for exactly one cycle, in the cycle after the clock edge that samples the last slice of a sample. `iData`/`qData` hold their value between pulses.
- R7: A frame mark occurs when strobe slice bit 7 is 1 and the last valid strobe bit of the previous slice was 0. That bit is bit 4 in SDR and bit 0 in DDR. No valid is produced before the first mark after reset.
- R8: A mark that arrives while a sample is partly assembled discards that partial sample. The new sample is counted from the marked slice.
- R9: After the first mark, samples keep being emitted at the ratio even when no further marks arrive.
- R10: A `laneCount` value other than 2 or 4 is treated as one lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous reset, active high |
| laneData | input | 32 | Four 8-bit lane slices, lane k at bits [8k+7:8k] |
| strobeData | input | 8 | Strobe lane slice |
| laneCount | input | 5 | Active lane count (2, 4, any other value means 1) |
| sdrSel | input | 1 | 1 selects SDR capture, 0 selects DDR |
| symbEn | input | 1 | 1 enables symbol mode |
| symbNarrow | input | 1 | In symbol mode, 1 selects 8-bit symbols and 0 selects 16-bit symbols |
| validOut | output | 1 | One-cycle pulse per recovered sample |
| iData | output | 16 | Recovered in-phase word |
| qData | output | 16 | Recovered quadrature word |

## Verification
Every result has one register between the slice that completes a sample and the outputs. The valid pulse and the new I/Q words are therefore due in the cycle after the edge that samples the last slice. The bench drives each slice just after a falling edge. At the next falling edge it checks `validOut` against the flag it set when it drove the previous slice, so every cycle is checked for both the presence and the absence of a pulse. The idle cycles before a mark and the discarded partial sample after a mid-sample mark are checked in the same way. After each run the bench also confirms the count of pulses.

// File: rtl/ssiDeframePkg.sv
package ssiDeframePkg;
  localparam int MAX_LANES = 4;

  typedef enum logic [1:0] {
    LANES_ONE  = 2'd0,
    LANES_TWO  = 2'd1,
    LANES_FOUR = 2'd2
  } laneMode_e;

  typedef struct packed {
    laneMode_e lanes;
    logic      sdr;
    logic      symbOn;
    logic      symb8;
  } modeSel_t;

  // control -> datapath strobes
  typedef struct packed {
    logic restart;
    logic emit;
  } frameStrobe_t;
endpackage

// File: rtl/ssiDeframeCtrl.sv
module ssiDeframeCtrl
  import ssiDeframePkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int SAMPLE_W   = 32,
  parameter int SYM_WIDE   = 16,
  parameter int SYM_NARROW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  modeSel_t           mode,
  input  logic [SLICE_W-1:0] strobeSlice,
  output frameStrobe_t       strb
);
  localparam int CNT_W      = $clog2(SAMPLE_W * 2 / SLICE_W);
  localparam int IDX_W      = $clog2(SLICE_W);
  localparam int SAMPLE_LOG = $clog2(SAMPLE_W);
  localparam int WIDE_LOG   = $clog2(SYM_WIDE);
  localparam int NARROW_LOG = $clog2(SYM_NARROW);
  localparam int DDR_LOG    = $clog2(SLICE_W);
  localparam int SDR_LOG    = DDR_LOG - 1;

  int               bitsLog;
  int               beatsLog;
  logic [CNT_W-1:0] beatsLast;
  logic [CNT_W-1:0] beatCnt;
  logic [IDX_W-1:0] lastIdx;
  logic             locked;
  logic             prevLast;
  logic             mark;
  logic             atEnd;

  // beats per sample = bits per lane per sample / bits per lane per clock
  always_comb begin
    if (mode.symbOn) begin
      bitsLog = mode.symb8 ? NARROW_LOG : WIDE_LOG;
    end else begin
      case (mode.lanes)
        LANES_TWO:  bitsLog = SAMPLE_LOG - 1;
        LANES_FOUR: bitsLog = SAMPLE_LOG - 2;
        default:    bitsLog = SAMPLE_LOG;
      endcase
    end
    beatsLog  = bitsLog - (mode.sdr ? SDR_LOG : DDR_LOG);
    beatsLast = CNT_W'((1 << beatsLog) - 1);
  end

  always_comb begin
    lastIdx     = mode.sdr ? IDX_W'(SLICE_W / 2) : '0;
    mark        = strobeSlice[SLICE_W-1] & ~prevLast;
    atEnd       = (beatCnt == beatsLast);
    strb.restart = mark;
    strb.emit    = mark ? (beatsLast == '0) : (locked & atEnd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked   <= 1'b0;
      beatCnt  <= '0;
      prevLast <= 1'b0;
    end else begin
      prevLast <= strobeSlice[lastIdx];
      if (mark) begin
        locked  <= 1'b1;
        beatCnt <= (beatsLast == '0) ? '0 : CNT_W'(1);
      end else if (locked) begin
        beatCnt <= atEnd ? '0 : beatCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ssiDeframeData.sv
module ssiDeframeData
  import ssiDeframePkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int SAMPLE_W   = 32,
  parameter int SYM_WIDE   = 16,
  parameter int SYM_NARROW = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [MAX_LANES*SLICE_W-1:0] laneSlices,
  input  modeSel_t                     mode,
  input  frameStrobe_t                 strb,
  output logic                         validOut,
  output logic [SAMPLE_W/2-1:0]        iData,
  output logic [SAMPLE_W/2-1:0]        qData
);
  localparam int HALF    = SAMPLE_W / 2;
  localparam int HALF_SL = SLICE_W / 2;
  localparam int SEG2    = SAMPLE_W / 2;
  localparam int SEG4    = SAMPLE_W / 4;
  localparam int WH      = SYM_WIDE / 2;
  localparam int NH      = SYM_NARROW / 2;

  logic [SAMPLE_W-1:0] laneNext [MAX_LANES];
  logic [SAMPLE_W-1:0] word4;
  logic [SAMPLE_W-1:0] word;

  for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
    logic [SAMPLE_W-1:0] shReg;
    logic [SAMPLE_W-1:0] base;
    logic [SLICE_W-1:0]  slice;

    always_comb begin
      slice = laneSlices[k*SLICE_W +: SLICE_W];
      base  = strb.restart ? '0 : shReg;
      if (mode.sdr) laneNext[k] = {base[SAMPLE_W-HALF_SL-1:0], slice[SLICE_W-1 -: HALF_SL]};
      else          laneNext[k] = {base[SAMPLE_W-SLICE_W-1:0], slice};
    end

    always_ff @(posedge clk) begin
      if (rst) shReg <= '0;
      else     shReg <= laneNext[k];
    end

    assign word4[SAMPLE_W-1-k*SEG4 -: SEG4] = laneNext[k][SEG4-1:0];
  end

  always_comb begin
    if (mode.symbOn) begin
      if (mode.symb8)
        word = {laneNext[0][2*NH-1 -: NH], {(HALF-NH){1'b0}},
                laneNext[0][NH-1:0], {(HALF-NH){1'b0}}};
      else
        word = {laneNext[0][2*WH-1 -: WH], {(HALF-WH){1'b0}},
                laneNext[0][WH-1:0], {(HALF-WH){1'b0}}};
    end else begin
      case (mode.lanes)
        LANES_TWO:  word = {laneNext[0][SEG2-1:0], laneNext[1][SEG2-1:0]};
        LANES_FOUR: word = word4;
        default:    word = laneNext[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validOut <= 1'b0;
      iData    <= '0;
      qData    <= '0;
    end else begin
      validOut <= strb.emit;
      if (strb.emit) begin
        iData <= word[SAMPLE_W-1:HALF];
        qData <= word[HALF-1:0];
      end
    end
  end
endmodule

// File: rtl/ssiRxDeframer.sv
module ssiRxDeframer
  import ssiDeframePkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int SAMPLE_W   = 32,
  parameter int SYM_WIDE   = 16,
  parameter int SYM_NARROW = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [MAX_LANES*SLICE_W-1:0] laneData,
  input  logic [SLICE_W-1:0]           strobeData,
  input  logic [4:0]                   laneCount,
  input  logic                         sdrSel,
  input  logic                         symbEn,
  input  logic                         symbNarrow,
  output logic                         validOut,
  output logic [SAMPLE_W/2-1:0]        iData,
  output logic [SAMPLE_W/2-1:0]        qData
);
  modeSel_t     mode;
  frameStrobe_t strb;

  always_comb begin
    case (laneCount)
      5'd2:    mode.lanes = LANES_TWO;
      5'd4:    mode.lanes = LANES_FOUR;
      default: mode.lanes = LANES_ONE;
    endcase
    mode.sdr    = sdrSel;
    mode.symbOn = symbEn;
    mode.symb8  = symbNarrow;
  end

  ssiDeframeCtrl #(
    .SLICE_W(SLICE_W), .SAMPLE_W(SAMPLE_W),
    .SYM_WIDE(SYM_WIDE), .SYM_NARROW(SYM_NARROW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .mode(mode), .strobeSlice(strobeData), .strb(strb)
  );

  ssiDeframeData #(
    .SLICE_W(SLICE_W), .SAMPLE_W(SAMPLE_W),
    .SYM_WIDE(SYM_WIDE), .SYM_NARROW(SYM_NARROW)
  ) u_data (
    .clk(clk), .rst(rst), .laneSlices(laneData), .mode(mode), .strb(strb),
    .validOut(validOut), .iData(iData), .qData(qData)
  );
endmodule

// File: rtl/ssiRxDeframerChk.sv
module ssiRxDeframerChk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  strobeData,
  input logic [4:0]  laneCount,
  input logic        sdrSel,
  input logic        symbEn,
  input logic        symbNarrow,
  input logic        validOut,
  input logic [15:0] iData,
  input logic [15:0] qData
);
  logic sawStrobe;
  logic ratioAboveOne;

  always_ff @(posedge clk) begin
    if (rst)              sawStrobe <= 1'b0;
    else if (|strobeData) sawStrobe <= 1'b1;
  end

  assign ratioAboveOne = sdrSel ||
                         !((!symbEn && laneCount == 5'd4) || (symbEn && symbNarrow));

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!validOut && iData == 16'h0 && qData == 16'h0));

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    (validOut && ratioAboveOne) |=> !validOut);

  p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> $stable({iData, qData}));

  p_mark_first_r7: assert property (@(posedge clk) disable iff (rst)
    validOut |-> sawStrobe);

  p_symbol_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (validOut && symbEn) |->
      (symbNarrow ? (iData[11:0] == 12'h0 && qData[11:0] == 12'h0)
                  : (iData[7:0] == 8'h0 && qData[7:0] == 8'h0)));
endmodule

bind ssiRxDeframer ssiRxDeframerChk u_chk (
  .clk(clk), .rst(rst), .strobeData(strobeData), .laneCount(laneCount),
  .sdrSel(sdrSel), .symbEn(symbEn), .symbNarrow(symbNarrow),
  .validOut(validOut), .iData(iData), .qData(qData)
);

// File: tb/tb_ssiRxDeframer.sv
module tb_ssiRxDeframer;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 50000;

  typedef struct packed {
    logic [4:0] lanes;
    logic       sdr;
    logic       symb;
    logic       narrow;
    logic [3:0] ratio;
  } modeVec_t;

  localparam int NMODES = 12;
  localparam modeVec_t MODES [NMODES] = '{
    '{5'd1, 1'b1, 1'b0, 1'b0, 4'd8},
    '{5'd1, 1'b0, 1'b0, 1'b0, 4'd4},
    '{5'd2, 1'b1, 1'b0, 1'b0, 4'd4},
    '{5'd2, 1'b0, 1'b0, 1'b0, 4'd2},
    '{5'd4, 1'b1, 1'b0, 1'b0, 4'd2},
    '{5'd4, 1'b0, 1'b0, 1'b0, 4'd1},
    '{5'd1, 1'b1, 1'b1, 1'b0, 4'd4},
    '{5'd4, 1'b0, 1'b1, 1'b0, 4'd2},
    '{5'd2, 1'b1, 1'b1, 1'b1, 4'd2},
    '{5'd1, 1'b0, 1'b1, 1'b1, 4'd1},
    '{5'd3, 1'b0, 1'b0, 1'b0, 4'd4},
    '{5'd0, 1'b1, 1'b0, 1'b0, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] laneData = '0;
  logic [7:0]  strobeData = '0;
  logic [4:0]  laneCount = 5'd1;
  logic        sdrSel = 1'b0;
  logic        symbEn = 1'b0;
  logic        symbNarrow = 1'b0;
  logic        validOut;
  logic [15:0] iData;
  logic [15:0] qData;

  int    checks = 0;
  int    fails = 0;
  int    validSeen = 0;
  logic  pendValid = 1'b0;
  logic [15:0] expI = '0;
  logic [15:0] expQ = '0;
  string pendTag = "R7 idle";

  always #(CLK_PERIOD/2) clk = ~clk;

  ssiRxDeframer dut (
    .clk(clk), .rst(rst), .laneData(laneData), .strobeData(strobeData),
    .laneCount(laneCount), .sdrSel(sdrSel), .symbEn(symbEn), .symbNarrow(symbNarrow),
    .validOut(validOut), .iData(iData), .qData(qData)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int bitsPerLane(input modeVec_t m);
    if (m.symb) return m.narrow ? 8 : 16;
    if (m.lanes == 5'd2) return 16;
    if (m.lanes == 5'd4) return 8;
    return 32;
  endfunction

  function automatic logic [31:0] laneBits(input modeVec_t m, input logic [15:0] i,
                                           input logic [15:0] q, input int k);
    logic [31:0] junk;
    junk = {q, i} ^ 32'h5A3C_96E1 ^ 32'(k);
    if (m.symb) begin
      if (k != 0) return junk;
      return m.narrow ? {24'h0, i[15:12], q[15:12]} : {16'h0, i[15:8], q[15:8]};
    end
    if (m.lanes == 5'd2) begin
      if (k == 0) return {16'h0, i};
      if (k == 1) return {16'h0, q};
      return junk;
    end
    if (m.lanes == 5'd4) begin
      case (k)
        0: return {24'h0, i[15:8]};
        1: return {24'h0, i[7:0]};
        2: return {24'h0, q[15:8]};
        default: return {24'h0, q[7:0]};
      endcase
    end
    return (k == 0) ? {i, q} : junk;
  endfunction

  function automatic logic [7:0] sliceFor(input logic [31:0] bits, input int len,
                                          input int b, input int j);
    logic [7:0] s;
    s = '0;
    for (int t = 0; t < b; t++) s[7-t] = bits[len-1-j*b-t];
    return s;
  endfunction

  task automatic evalPending();
    check(validOut === pendValid, {pendTag, " valid timing R6"}, {31'h0, validOut}, {31'h0, pendValid});
    if (pendValid)
      check({iData, qData} === {expI, expQ}, pendTag, {iData, qData}, {expI, expQ});
    if (validOut === 1'b1) validSeen++;
  endtask

  task automatic tick(input logic [31:0] lanes, input logic [7:0] strb);
    @(negedge clk);
    evalPending();
    laneData   = lanes;
    strobeData = strb;
  endtask

  task automatic sendSample(input modeVec_t m, input logic [15:0] i, input logic [15:0] q,
                            input bit mark, input int nBeats, input string tag);
    int len, b, beats;
    logic [31:0] lanes;
    logic [7:0] strb;
    len = bitsPerLane(m);
    b = m.sdr ? 4 : 8;
    beats = len / b;
    for (int j = 0; j < nBeats; j++) begin
      for (int k = 0; k < 4; k++) lanes[k*8 +: 8] = sliceFor(laneBits(m, i, q, k), len, b, j);
      strb = (j == 0 && mark) ? (m.sdr ? 8'hC0 : 8'hF0) : 8'h00;
      tick(lanes, strb);
      pendValid = (j == beats - 1);
      pendTag = tag;
      if (m.symb) begin
        expI = m.narrow ? {i[15:12], 12'h0} : {i[15:8], 8'h0};
        expQ = m.narrow ? {q[15:12], 12'h0} : {q[15:8], 8'h0};
      end else begin
        expI = i;
        expQ = q;
      end
    end
  endtask

  task automatic applyMode(input modeVec_t m);
    @(negedge clk);
    rst = 1'b1;
    laneCount = m.lanes;
    sdrSel = m.sdr;
    symbEn = m.symb;
    symbNarrow = m.narrow;
    laneData = '0;
    strobeData = '0;
    pendValid = 1'b0;
    pendTag = "R7 idle";
    @(negedge clk);
    @(negedge clk);
    check(validOut === 1'b0 && iData === 16'h0 && qData === 16'h0, "R1 reset state",
          {15'h0, validOut, iData}, 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    modeVec_t m;
    string tag;
    // table walk: every lane / capture / symbol combination
    for (int mi = 0; mi < NMODES; mi++) begin
      m = MODES[mi];
      applyMode(m);
      for (int n = 0; n < 3; n++) tick('0, 8'h00);   // R7: no valid before a mark
      validSeen = 0;
      for (int n = 0; n < 5; n++) begin
        if (m.symb) tag = "R4 symbol";
        else if (m.lanes == 5'd2 || m.lanes == 5'd4) tag = "R2 lanes";
        else if (m.lanes == 5'd1) tag = "R3 capture";
        else tag = "R10 lane fallback";
        if (n == 3) tag = "R9 free-run";
        sendSample(m, 16'h1234 + 16'(n * 16'h0305) + 16'(mi * 16'h1111),
                   16'hF00D - 16'(n * 16'h0407) - 16'(mi * 16'h0101),
                   n != 3, int'(m.ratio), tag);
      end
      tick('0, 8'h00);
      pendValid = 1'b0;
      check(validSeen == 5, "R5 pulses per run", 32'(validSeen), 32'd5);
    end

    // R8: mark in the middle of a sample discards the partial one
    m = MODES[1];
    applyMode(m);
    validSeen = 0;
    sendSample(m, 16'hDEAD, 16'hBEEF, 1'b1, 2, "R8 partial");
    sendSample(m, 16'h4C2B, 16'h91E7, 1'b1, 4, "R8 restart");
    tick('0, 8'h00);
    pendValid = 1'b0;
    check(validSeen == 1, "R8 one pulse", 32'(validSeen), 32'd1);
    check({iData, qData} === 32'h4C2B_91E7, "R6 hold after pulse", {iData, qData}, 32'h4C2B_91E7);

    // R1: reset in the middle of traffic clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(validOut === 1'b0 && iData === 16'h0 && qData === 16'h0, "R1 mid-run reset",
          {15'h0, validOut, iData}, 32'h0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule